// File: doc/BRIEF.md
# Image Sensor Power-State Sequencer

This controller runs on the sensor's external clock and walks the sensor through its power and reset states. It starts in a low-power hardware standby. It then waits for the internal power-on timer, runs a fixed-length internal initialization and parks in a soft standby. From soft standby a streaming request starts the oscillator and waits a fixed lock interval with the PLL output bypassed. After that interval the PLL clock becomes active and the sensor streams. Dropping the request lets the current frame finish before the sensor returns to soft standby.

The block has two reset paths. The reset pin is active low and resets the controller asynchronously from any state; it is released through a two-stage synchronizer. A soft-reset write strobe sends the controller from any post-power-on state back into initialization, with the oscillator forced off. A soft reset that cuts a frame short raises a one-cycle abort pulse. The serial-bus engine uses a read-acknowledge flag to decide whether register reads may be answered or must receive a NACK.

Top module: `sensor_pwr_seq`

## Requirements
- R1: While `rst_pin_n` is low, `state_o` is 0 (hardware standby), `rd_ack_ok` is 0, `vco_en` is 0, `pll_bypass` is 1 and `frame_abort` is 0.
- R2: After `rst_pin_n` rises, the synchronizer releases on the second rising edge. On the third edge the state moves from 0 to 1 (power-on wait). State 1 moves to 2 (initialization) on the first edge at which `por_done` is high, so initialization starts only after both the pin and the power-on timer have released.
- R3: A falling edge on `rst_pin_n` forces `state_o` to 0 at once, without waiting for a clock edge, from any state including streaming.
- R4: Initialization (state 2) lasts exactly INIT_CYCLES clock cycles and then moves to soft standby (state 3).
- R5: `rd_ack_ok` is 0 in states 0, 1 and 2 and is 1 in states 3, 4, 5 and 6.
- R6: In state 3 with `stream_req` high, the state moves to PLL lock (state 4). State 4 lasts exactly LOCK_CYCLES cycles and then moves to streaming (state 5).
- R7: In state 5, `stream_req` low moves the state to frame-end wait (state 6). In state 6, `frame_end` high moves it to state 3, and `stream_req` has no effect there. `frame_end` has no effect in state 5.
- R8: `vco_en` is 1 only in states 4, 5 and 6. `pll_bypass` is 0 only in states 5 and 6.
- R9: `sw_reset_wr` high in any of states 2 to 6 moves the state to 2 on the next edge and restarts the initialization count, ahead of every other transition. It has no effect in states 0 and 1.
- R10: `frame_abort` is high for exactly the one cycle after an edge at which `sw_reset_wr` was taken in state 5 or 6, and is low at all other times.
- R11: The state code on `state_o` is hardware standby 0, power-on wait 1, initialization 2, soft standby 3, PLL lock 4, streaming 5, frame-end wait 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | External sensor clock |
| rst_pin_n | input | 1 | Active-low reset pin, asserted asynchronously |
| por_done | input | 1 | Internal power-on timer has expired (level) |
| stream_req | input | 1 | Streaming requested (level) |
| sw_reset_wr | input | 1 | One-cycle strobe: a 1 was written to the soft-reset register |
| frame_end | input | 1 | One-cycle strobe at the end of a frame |
| state_o | output | 3 | Current state code (see R11) |
| rd_ack_ok | output | 1 | Register reads may be acknowledged |
| pll_bypass | output | 1 | 1 selects the external clock, 0 the PLL output |
| vco_en | output | 1 | Oscillator power enable |
| frame_abort | output | 1 | One-cycle pulse: a frame was cut short by a soft reset |

## Verification
The reset pin is released once with the power-on flag still low and once with it already high. This shows that the later of the two events decides when initialization starts. Full runs of initialization and lock compare the state on every clock, so a count that is off by one cycle shows up as a mismatch. Soft-reset strobes are placed in streaming, frame-end wait, PLL lock, mid-initialization and power-on wait, which separates the states that abort a frame from those that only restart initialization or ignore the strobe. Frame-end pulses during streaming and request re-assertion during frame-end wait confirm that those inputs are ignored outside the states that use them.

// File: rtl/sps_pkg.sv
package sps_pkg;

  typedef enum logic [2:0] {
    ST_HW_STBY    = 3'd0,
    ST_POR_WAIT   = 3'd1,
    ST_INIT       = 3'd2,
    ST_SOFT_STBY  = 3'd3,
    ST_PLL_LOCK   = 3'd4,
    ST_STREAM     = 3'd5,
    ST_FRAME_WAIT = 3'd6
  } pwr_state_t;

  // PLL clock drives the array only while a frame can be running
  function automatic logic clk_live(input pwr_state_t s);
    return (s == ST_STREAM) || (s == ST_FRAME_WAIT);
  endfunction

  // states reached only once power-on initialization has begun
  function automatic logic post_por(input pwr_state_t s);
    return (s != ST_HW_STBY) && (s != ST_POR_WAIT);
  endfunction

endpackage

// File: rtl/sps_rst_sync.sv
module sps_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n = sync_q[1];
endmodule

// File: rtl/sps_cycle_timer.sv
module sps_cycle_timer #(
  parameter int CW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          clr,
  input  logic [CW-1:0] limit,
  output logic [CW-1:0] cnt,
  output logic          last
);
  logic cnt_en;

  assign last   = run && (cnt == (limit - 1'b1));
  assign cnt_en = run && !clr && !last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (clr || !run)  cnt <= '0;
    else if (cnt_en)       cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/sps_out_decode.sv
module sps_out_decode
  import sps_pkg::*;
(
  input  pwr_state_t st,
  output logic       rd_ack_ok,
  output logic       vco_en,
  output logic       pll_bypass
);
  always_comb begin
    rd_ack_ok  = post_por(st) && (st != ST_INIT);
    vco_en     = (st == ST_PLL_LOCK) || clk_live(st);
    pll_bypass = !clk_live(st);
  end
endmodule

// File: rtl/sensor_pwr_seq.sv
module sensor_pwr_seq
  import sps_pkg::*;
#(
  parameter int INIT_CYCLES = 700,
  parameter int LOCK_CYCLES = 6750
) (
  input  logic       clk,
  input  logic       rst_pin_n,
  input  logic       por_done,
  input  logic       stream_req,
  input  logic       sw_reset_wr,
  input  logic       frame_end,
  output logic [2:0] state_o,
  output logic       rd_ack_ok,
  output logic       pll_bypass,
  output logic       vco_en,
  output logic       frame_abort
);
  localparam int MAX_CYC = (INIT_CYCLES > LOCK_CYCLES) ? INIT_CYCLES : LOCK_CYCLES;
  localparam int CW      = $clog2(MAX_CYC + 1);

  logic          rst_n;
  pwr_state_t    state_q, state_d;
  logic          sw_hit, abort_d, abort_q;
  logic          tmr_run, tmr_clr, tmr_last;
  logic [CW-1:0] tmr_cnt, tmr_limit;

  sps_rst_sync u_rst_sync (
    .clk    (clk),
    .arst_n (rst_pin_n),
    .rst_n  (rst_n)
  );

  assign sw_hit  = sw_reset_wr && post_por(state_q);
  assign abort_d = sw_hit && clk_live(state_q);

  // next-state logic
  always_comb begin
    state_d = state_q;
    if (sw_hit) begin
      state_d = ST_INIT;
    end else begin
      case (state_q)
        ST_HW_STBY:    state_d = ST_POR_WAIT;
        ST_POR_WAIT:   if (por_done)    state_d = ST_INIT;
        ST_INIT:       if (tmr_last)    state_d = ST_SOFT_STBY;
        ST_SOFT_STBY:  if (stream_req)  state_d = ST_PLL_LOCK;
        ST_PLL_LOCK:   if (tmr_last)    state_d = ST_STREAM;
        ST_STREAM:     if (!stream_req) state_d = ST_FRAME_WAIT;
        ST_FRAME_WAIT: if (frame_end)   state_d = ST_SOFT_STBY;
        default:                        state_d = ST_HW_STBY;
      endcase
    end
  end

  assign tmr_run   = (state_q == ST_INIT) || (state_q == ST_PLL_LOCK);
  assign tmr_clr   = (state_d != state_q) || sw_hit;
  assign tmr_limit = (state_q == ST_INIT) ? CW'(INIT_CYCLES) : CW'(LOCK_CYCLES);

  sps_cycle_timer #(.CW(CW)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (tmr_run),
    .clr   (tmr_clr),
    .limit (tmr_limit),
    .cnt   (tmr_cnt),
    .last  (tmr_last)
  );

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_HW_STBY;
      abort_q <= 1'b0;
    end else begin
      state_q <= state_d;
      abort_q <= abort_d;
    end
  end

  sps_out_decode u_decode (
    .st         (state_q),
    .rd_ack_ok  (rd_ack_ok),
    .vco_en     (vco_en),
    .pll_bypass (pll_bypass)
  );

  assign state_o     = state_q;
  assign frame_abort = abort_q;

  // ---------------- assertions ----------------
  assert_init_leave_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_INIT && $past(state_q) == ST_POR_WAIT) |-> $past(por_done))
    else $error("init entered without power-on timeout");

  assert_init_len_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SOFT_STBY && $past(state_q) == ST_INIT) |-> ($past(tmr_cnt) == CW'(INIT_CYCLES - 1)))
    else $error("initialization length wrong");

  assert_lock_len_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_STREAM && $past(state_q) == ST_PLL_LOCK) |-> ($past(tmr_cnt) == CW'(LOCK_CYCLES - 1)))
    else $error("lock length wrong");

  assert_rdack_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_ack_ok) |-> ($past(state_q) == ST_INIT))
    else $error("read acknowledge enabled outside init completion");

  assert_pll_switch_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pll_bypass) |-> ($past(state_q) == ST_PLL_LOCK && $past(vco_en)))
    else $error("PLL output selected without a lock interval");

  assert_abort_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    frame_abort |=> !frame_abort)
    else $error("abort pulse longer than one cycle");

  assert_abort_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    frame_abort |-> (state_q == ST_INIT && $past(sw_reset_wr)))
    else $error("abort without soft reset");

endmodule

// File: tb/sensor_pwr_seq_tb.sv
module sensor_pwr_seq_tb;
  localparam int CLK_PERIOD = 10;
  localparam int INIT_N = 700;
  localparam int LOCK_N = 6750;

  logic clk = 1'b0;
  logic rst_pin_n, por_done, stream_req, sw_reset_wr, frame_end;
  logic [2:0] state_o;
  logic rd_ack_ok, pll_bypass, vco_en, frame_abort;

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;
  bit chk_en = 0;

  // reference model state
  int m_state = 0;
  int m_cnt = 0;
  int m_sync = 0;
  bit m_abort = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sensor_pwr_seq #(.INIT_CYCLES(INIT_N), .LOCK_CYCLES(LOCK_N)) u_dut (
    .clk(clk), .rst_pin_n(rst_pin_n), .por_done(por_done),
    .stream_req(stream_req), .sw_reset_wr(sw_reset_wr), .frame_end(frame_end),
    .state_o(state_o), .rd_ack_ok(rd_ack_ok), .pll_bypass(pll_bypass),
    .vco_en(vco_en), .frame_abort(frame_abort)
  );

  task automatic chk(input string tag, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic string state_tag(input int s);
    case (s)
      0, 1:    return "R2/R11 state";
      2:       return "R4/R9 state";
      3, 4, 5: return "R6 state";
      default: return "R7 state";
    endcase
  endfunction

  // asynchronous reset of the model
  always @(negedge rst_pin_n) begin
    m_state = 0; m_cnt = 0; m_sync = 0; m_abort = 0;
  end

  // behavioural model step on each edge
  always @(posedge clk) begin
    if (rst_pin_n === 1'b1) begin
      if (m_sync == 2) begin
        int nxt;
        bit sw;
        nxt = m_state;
        sw = sw_reset_wr && (m_state >= 2);
        m_abort = sw && (m_state == 5 || m_state == 6);
        if (sw) begin
          nxt = 2; m_cnt = -1;
        end else if (m_state == 0) nxt = 1;
        else if (m_state == 1) begin if (por_done) nxt = 2; end
        else if (m_state == 2) begin if (m_cnt == INIT_N-1) nxt = 3; end
        else if (m_state == 3) begin if (stream_req) nxt = 4; end
        else if (m_state == 4) begin if (m_cnt == LOCK_N-1) nxt = 5; end
        else if (m_state == 5) begin if (!stream_req) nxt = 6; end
        else if (m_state == 6) begin if (frame_end) nxt = 3; end
        if (nxt != m_state || m_cnt < 0) m_cnt = 0;
        else m_cnt = m_cnt + 1;
        m_state = nxt;
      end else begin
        m_abort = 0;
      end
      if (m_sync < 2) m_sync++;
    end
  end

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (chk_en && !finished) begin
      chk(state_tag(m_state), int'(state_o), m_state);
      chk("R5 rd_ack_ok", int'(rd_ack_ok), (m_state >= 3) ? 1 : 0);
      chk("R8 vco_en", int'(vco_en), (m_state >= 4 && m_state <= 6) ? 1 : 0);
      chk("R8 pll_bypass", int'(pll_bypass), (m_state == 5 || m_state == 6) ? 0 : 1);
      chk("R10 frame_abort", int'(frame_abort), int'(m_abort));
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  task automatic wait_state(input int s);
    int n = 0;
    while (m_state != s && n < 20000) begin
      @(negedge clk); n++;
    end
    if (m_state != s) chk("wait_state model", m_state, s);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse_sw();
    @(negedge clk); sw_reset_wr = 1'b1;
    @(negedge clk); sw_reset_wr = 1'b0;
  endtask

  task automatic pulse_fe();
    @(negedge clk); frame_end = 1'b1;
    @(negedge clk); frame_end = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    mismatched++;
    $display("FAIL watchdog R1 actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    rst_pin_n = 1'b0; por_done = 1'b0; stream_req = 1'b0;
    sw_reset_wr = 1'b0; frame_end = 1'b0;
    idle(5);
    chk_en = 1;
    // R1: reset values at the ports
    chk("R1 state", int'(state_o), 0);
    chk("R1 rd_ack_ok", int'(rd_ack_ok), 0);
    chk("R1 vco_en", int'(vco_en), 0);
    chk("R1 pll_bypass", int'(pll_bypass), 1);
    chk("R1 frame_abort", int'(frame_abort), 0);

    // R2: pin released first, power-on timer later
    rst_pin_n = 1'b1;
    idle(12);
    chk("R2 held in por wait", int'(state_o), 1);
    pulse_sw();                       // R9: ignored in power-on wait
    idle(2);
    chk("R9 sw ignored in por wait", int'(state_o), 1);
    por_done = 1'b1;
    wait_state(3);                    // R4: init runs to soft standby

    // R6: lock, then stream; R7: frame_end ignored while streaming
    stream_req = 1'b1;
    wait_state(5);
    repeat (3) pulse_fe();
    chk("R7 frame_end ignored in stream", int'(state_o), 5);

    // R7: stop, request re-asserted in frame wait is ignored
    stream_req = 1'b0;
    wait_state(6);
    @(negedge clk); stream_req = 1'b1;
    idle(5);
    chk("R7 req ignored in frame wait", int'(state_o), 6);
    pulse_fe();
    wait_state(5);

    // R9/R10: soft reset while streaming aborts the frame
    pulse_sw();
    chk("R10 abort after stream reset", int'(frame_abort), 1);
    idle(300);
    pulse_sw();                       // R9: restart mid-initialization
    stream_req = 1'b0;
    wait_state(3);

    // R9: soft reset during lock, no abort
    stream_req = 1'b1;
    wait_state(4);
    idle(100);
    pulse_sw();
    chk("R9 lock reset no abort", int'(frame_abort), 0);
    wait_state(5);

    // R10: soft reset in frame-end wait aborts
    stream_req = 1'b0;
    wait_state(6);
    idle(3);
    pulse_sw();
    chk("R10 abort after frame wait reset", int'(frame_abort), 1);
    stream_req = 1'b1;
    wait_state(5);
    idle(4);

    // R3: pin assertion mid-stream acts at once
    #2 rst_pin_n = 1'b0;
    #1;
    chk("R3 async state", int'(state_o), 0);
    chk("R3 async vco", int'(vco_en), 0);
    idle(3);

    // R2: power-on timer already expired, pin released last
    stream_req = 1'b0;
    @(negedge clk); rst_pin_n = 1'b1;
    idle(4);
    chk("R2 init after pin release", int'(state_o), 2);
    wait_state(3);
    idle(5);
    finish_run();
  end
endmodule